// File: doc/BRIEF.md
# PHY Discovery and Autonegotiation Sequencer

This controller brings up an Ethernet PHY through a separate management frame engine, which it drives with a simple request and acknowledge port. After a start pulse it scans the PHY addresses for the first device that returns a believable identifier. It then resets that PHY and loads the advertisement register from the PHY's own capability bits. Finally it restarts autonegotiation and polls for the outcome.

The result is held on flag outputs until the next start. The flags are a success flag, three distinct failure flags, the chosen PHY address, and the line speed and duplex. Speed and duplex come from a vendor status snapshot taken before negotiation. Every wait between polls lasts until the next pulse on a tick input, so a system can use a slow tick and a simulation can use a fast one.

Top module: `phy_autoneg_seq`

## Requirements
- R1: A request is signalled by `mgmt_req_o` together with `mgmt_we_o` (1 for a write), `mgmt_phy_o`, `mgmt_reg_o` and `mgmt_wdata_o`. These fields stay stable until a cycle in which `mgmt_ack_i` is high, and that cycle completes the request. Read data is taken from `mgmt_rdata_i` in the acknowledge cycle.
- R2: Discovery reads register 2 and then register 3 at each PHY address. It steps the address upward from 0 and stops at the first address that qualifies.
- R3: An address qualifies when both identifier words are neither 0x0000 nor 0xFFFF, and neither word is 0x8000. The address that qualifies appears on `phy_addr_o`.
- R4: When no address from 0 to 31 qualifies, the run ends with `no_phy_o` set and no further request is made.
- R5: The PHY is reset by writing 0x8000 to register 0. Register 0 is then read until bit 15 reads 0, with at most 6 reads and one tick pulse between reads. If bit 15 is still set on the sixth read, the run ends with `rst_tmo_o` set.
- R6: After the reset completes, register 18 is read once and kept. The mask word (default 0xFC00) is then written to register 19, and register 1 is read for capabilities.
- R7: The capabilities read from register 1 set the bits of the word written to register 4. Bit 0 is always set. Status bits 15, 14, 13, 12 and 11 map in turn to advertisement bits 9, 8, 7, 6 and 5.
- R8: Autonegotiation is restarted by writing 0x1200 to register 0. Register 1 is then polled at most 20 times, with one tick pulse between polls.
- R9: When a poll shows bit 4 (remote fault) set and bit 5 (complete) clear, 0x3300 is written to register 0 before the next tick wait. This does not apply to the twentieth poll.
- R10: A poll that shows bit 5 set ends the run. The result is `ok_o` when bit 4 is clear and `an_fail_o` when bit 4 is set. If the twentieth poll shows bit 5 clear, the run ends with `an_fail_o`.
- R11: When the negotiation phase ends, `spd100_o` takes bit 7 and `fdx_o` takes bit 6 of the saved register 18 word. This holds whether negotiation succeeded or failed. Both outputs are 0 after the other kinds of failure.
- R12: `start_i` has no effect while `busy_o` is high. A start clears all result outputs. `done_o` is high for exactly one cycle at the end of a run, and `busy_o` is low in that cycle.
- R13: Out of reset, `busy_o`, `done_o`, `mgmt_req_o` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a bring-up run (ignored while busy) |
| tick_i | input | 1 | Interval pulse ending each poll wait |
| mgmt_req_o | output | 1 | Management request pending |
| mgmt_we_o | output | 1 | Request is a write |
| mgmt_phy_o | output | 5 | Target PHY address |
| mgmt_reg_o | output | 5 | Target register number |
| mgmt_wdata_o | output | 16 | Write data |
| mgmt_ack_i | input | 1 | Request completed this cycle |
| mgmt_rdata_i | input | 16 | Read data, valid with acknowledge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| phy_addr_o | output | 5 | Address of the PHY that was found |
| ok_o | output | 1 | Negotiation completed without fault |
| no_phy_o | output | 1 | No address qualified |
| rst_tmo_o | output | 1 | PHY reset did not clear |
| an_fail_o | output | 1 | Negotiation faulted or timed out |
| spd100_o | output | 1 | 100 Mb/s detected |
| fdx_o | output | 1 | Full duplex detected |

## Verification
The hardest state to reach is the remote-fault path. It needs a status poll that shows fault without completion, then a restart write, then a later poll that either completes cleanly or completes with the fault still set. The bench reaches this path through a behavioural PHY whose status word is scripted per poll number: a fault window and a completion poll are set for each case. That same script also drives the twentieth-poll timeout and the reset that never clears. Each run's full transaction log is compared against a sequence derived from the requirements.

// File: rtl/aneg_pkg.sv
package aneg_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned REG_W  = 5;

  localparam logic [REG_W-1:0] REG_CTL   = 5'd0;
  localparam logic [REG_W-1:0] REG_STAT  = 5'd1;
  localparam logic [REG_W-1:0] REG_ID_HI = 5'd2;
  localparam logic [REG_W-1:0] REG_ID_LO = 5'd3;
  localparam logic [REG_W-1:0] REG_ADV   = 5'd4;
  localparam logic [REG_W-1:0] REG_VSTAT = 5'd18;
  localparam logic [REG_W-1:0] REG_MASK  = 5'd19;

  localparam int unsigned CTL_RST_B  = 15;
  localparam int unsigned CTL_SPD_B  = 13;
  localparam int unsigned CTL_ANEN_B = 12;
  localparam int unsigned CTL_ANRS_B = 9;
  localparam int unsigned CTL_DPX_B  = 8;
  localparam int unsigned ST_DONE_B  = 5;
  localparam int unsigned ST_RFLT_B  = 4;
  localparam int unsigned VS_SPD_B   = 7;
  localparam int unsigned VS_DPX_B   = 6;
  localparam int unsigned CAP_TOP_B  = 15;
  localparam int unsigned ADV_TOP_B  = 9;
  localparam int unsigned CAP_N      = 5;

  localparam logic [DATA_W-1:0] W_RESET = DATA_W'(1) << CTL_RST_B;
  localparam logic [DATA_W-1:0] W_ANRESTART =
    (DATA_W'(1) << CTL_ANEN_B) | (DATA_W'(1) << CTL_ANRS_B);
  localparam logic [DATA_W-1:0] W_ANFORCE =
    W_ANRESTART | (DATA_W'(1) << CTL_SPD_B) | (DATA_W'(1) << CTL_DPX_B);

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_ID1, ST_RD_ID2, ST_WR_RST, ST_RD_CTL, ST_WT_RST,
    ST_RD_VS, ST_WR_MSK, ST_RD_CAP, ST_WR_ADV, ST_WR_ANEG, ST_RD_STAT,
    ST_WR_RFLT, ST_WT_AN
  } seq_st_e;
endpackage

// File: rtl/aneg_id_qualify.sv
module aneg_id_qualify #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] id_a_i,
  input  logic [W-1:0] id_b_i,
  output logic         ok_o
);
  localparam logic [W-1:0] TOPBIT = {1'b1, {(W-1){1'b0}}};

  logic a_ok, b_ok;
  assign a_ok = (id_a_i != '0) && (id_a_i != '1) && (id_a_i != TOPBIT);
  assign b_ok = (id_b_i != '0) && (id_b_i != '1) && (id_b_i != TOPBIT);
  assign ok_o = a_ok && b_ok;
endmodule

// File: rtl/aneg_adv_map.sv
module aneg_adv_map
  import aneg_pkg::*;
(
  input  logic [CAP_N-1:0]  cap_i,  // status bits [15:11]
  output logic [DATA_W-1:0] adv_o
);
  localparam int unsigned ADV_LO = ADV_TOP_B - CAP_N + 1;

  assign adv_o[0] = 1'b1;  // CSMA selector
  assign adv_o[ADV_LO-1:1] = '0;
  assign adv_o[DATA_W-1:ADV_TOP_B+1] = '0;

  for (genvar i = 0; i < CAP_N; i++) begin : g_cap
    assign adv_o[ADV_LO+i] = cap_i[i];
  end
endmodule

// File: rtl/aneg_poll_ctr.sv
module aneg_poll_ctr #(
  parameter int unsigned LIMIT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(LIMIT - 1));

  // bound for both poll loops (R5 reset loop, R8 negotiation loop)
  assert_poll_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_i && last_o));
  assert_clr_inc_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && inc_i));
endmodule

// File: rtl/phy_autoneg_seq.sv
module phy_autoneg_seq
  import aneg_pkg::*;
#(
  parameter int unsigned PHY_ADDRS = 32,
  parameter int unsigned RST_POLLS = 6,
  parameter int unsigned AN_POLLS  = 20,
  parameter logic [15:0] MASK_WORD = 16'hFC00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        tick_i,
  output logic        mgmt_req_o,
  output logic        mgmt_we_o,
  output logic [4:0]  mgmt_phy_o,
  output logic [4:0]  mgmt_reg_o,
  output logic [15:0] mgmt_wdata_o,
  input  logic        mgmt_ack_i,
  input  logic [15:0] mgmt_rdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [4:0]  phy_addr_o,
  output logic        ok_o,
  output logic        no_phy_o,
  output logic        rst_tmo_o,
  output logic        an_fail_o,
  output logic        spd100_o,
  output logic        fdx_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(PHY_ADDRS - 1);

  seq_st_e            st_q;
  logic [ADDR_W-1:0]  addr_q, found_q;
  logic [DATA_W-1:0]  id_a_q, adv_w;
  logic [CAP_N-1:0]   cap_q;
  logic               vs_spd_q, vs_dpx_q;
  logic               done_q, ok_q, nophy_q, rtmo_q, anf_q, spd_q, fdx_q;
  logic               id_ok, rst_last, an_last;
  logic               rst_clr, rst_inc, an_clr, an_inc;
  logic               ack;

  assign ack = mgmt_ack_i;

  aneg_id_qualify #(.W(DATA_W)) u_idq (
    .id_a_i (id_a_q),
    .id_b_i (mgmt_rdata_i),
    .ok_o   (id_ok)
  );

  aneg_adv_map u_adv (
    .cap_i (cap_q),
    .adv_o (adv_w)
  );

  assign rst_clr = (st_q == ST_WR_RST) && ack;
  assign rst_inc = (st_q == ST_RD_CTL) && ack && mgmt_rdata_i[CTL_RST_B] && !rst_last;
  assign an_clr  = (st_q == ST_WR_ANEG) && ack;
  assign an_inc  = (st_q == ST_RD_STAT) && ack && !mgmt_rdata_i[ST_DONE_B] && !an_last;

  aneg_poll_ctr #(.LIMIT(RST_POLLS)) u_rst_ctr (
    .clk_i, .rst_ni, .clr_i(rst_clr), .inc_i(rst_inc), .last_o(rst_last)
  );

  aneg_poll_ctr #(.LIMIT(AN_POLLS)) u_an_ctr (
    .clk_i, .rst_ni, .clr_i(an_clr), .inc_i(an_inc), .last_o(an_last)
  );

  // request decode
  always_comb begin
    mgmt_req_o   = 1'b1;
    mgmt_we_o    = 1'b0;
    mgmt_reg_o   = REG_CTL;
    mgmt_wdata_o = '0;
    unique case (st_q)
      ST_RD_ID1:  mgmt_reg_o = REG_ID_HI;
      ST_RD_ID2:  mgmt_reg_o = REG_ID_LO;
      ST_WR_RST:  begin mgmt_we_o = 1'b1; mgmt_wdata_o = W_RESET; end
      ST_RD_CTL:  mgmt_reg_o = REG_CTL;
      ST_RD_VS:   mgmt_reg_o = REG_VSTAT;
      ST_WR_MSK:  begin mgmt_we_o = 1'b1; mgmt_reg_o = REG_MASK; mgmt_wdata_o = MASK_WORD; end
      ST_RD_CAP:  mgmt_reg_o = REG_STAT;
      ST_WR_ADV:  begin mgmt_we_o = 1'b1; mgmt_reg_o = REG_ADV; mgmt_wdata_o = adv_w; end
      ST_WR_ANEG: begin mgmt_we_o = 1'b1; mgmt_wdata_o = W_ANRESTART; end
      ST_RD_STAT: mgmt_reg_o = REG_STAT;
      ST_WR_RFLT: begin mgmt_we_o = 1'b1; mgmt_wdata_o = W_ANFORCE; end
      default:    mgmt_req_o = 1'b0;
    endcase
  end

  assign mgmt_phy_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      found_q  <= '0;
      id_a_q   <= '0;
      cap_q    <= '0;
      vs_spd_q <= 1'b0;
      vs_dpx_q <= 1'b0;
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      nophy_q  <= 1'b0;
      rtmo_q   <= 1'b0;
      anf_q    <= 1'b0;
      spd_q    <= 1'b0;
      fdx_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          ok_q    <= 1'b0;
          nophy_q <= 1'b0;
          rtmo_q  <= 1'b0;
          anf_q   <= 1'b0;
          spd_q   <= 1'b0;
          fdx_q   <= 1'b0;
          found_q <= '0;
          addr_q  <= '0;
          st_q    <= ST_RD_ID1;
        end
        ST_RD_ID1: if (ack) begin
          id_a_q <= mgmt_rdata_i;
          st_q   <= ST_RD_ID2;
        end
        ST_RD_ID2: if (ack) begin
          if (id_ok) begin
            found_q <= addr_q;
            st_q    <= ST_WR_RST;
          end else if (addr_q == LAST_ADDR) begin
            nophy_q <= 1'b1;
            done_q  <= 1'b1;
            st_q    <= ST_IDLE;
          end else begin
            addr_q <= addr_q + 1'b1;
            st_q   <= ST_RD_ID1;
          end
        end
        ST_WR_RST: if (ack) st_q <= ST_RD_CTL;
        ST_RD_CTL: if (ack) begin
          if (!mgmt_rdata_i[CTL_RST_B]) st_q <= ST_RD_VS;
          else if (rst_last) begin
            rtmo_q <= 1'b1;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else st_q <= ST_WT_RST;
        end
        ST_WT_RST: if (tick_i) st_q <= ST_RD_CTL;
        ST_RD_VS: if (ack) begin
          vs_spd_q <= mgmt_rdata_i[VS_SPD_B];
          vs_dpx_q <= mgmt_rdata_i[VS_DPX_B];
          st_q     <= ST_WR_MSK;
        end
        ST_WR_MSK: if (ack) st_q <= ST_RD_CAP;
        ST_RD_CAP: if (ack) begin
          cap_q <= mgmt_rdata_i[CAP_TOP_B -: CAP_N];
          st_q  <= ST_WR_ADV;
        end
        ST_WR_ADV:  if (ack) st_q <= ST_WR_ANEG;
        ST_WR_ANEG: if (ack) st_q <= ST_RD_STAT;
        ST_RD_STAT: if (ack) begin
          if (mgmt_rdata_i[ST_DONE_B] || an_last) begin
            ok_q   <= mgmt_rdata_i[ST_DONE_B] && !mgmt_rdata_i[ST_RFLT_B];
            anf_q  <= !mgmt_rdata_i[ST_DONE_B] || mgmt_rdata_i[ST_RFLT_B];
            spd_q  <= vs_spd_q;
            fdx_q  <= vs_dpx_q;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (mgmt_rdata_i[ST_RFLT_B]) st_q <= ST_WR_RFLT;
          else st_q <= ST_WT_AN;
        end
        ST_WR_RFLT: if (ack) st_q <= ST_WT_AN;
        ST_WT_AN:   if (tick_i) st_q <= ST_RD_STAT;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign phy_addr_o = found_q;
  assign ok_o       = ok_q;
  assign no_phy_o   = nophy_q;
  assign rst_tmo_o  = rtmo_q;
  assign an_fail_o  = anf_q;
  assign spd100_o   = spd_q;
  assign fdx_o      = fdx_q;

  assert_req_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_req_o && !mgmt_ack_i |=> mgmt_req_o && $stable(mgmt_we_o) &&
      $stable(mgmt_phy_o) && $stable(mgmt_reg_o) && $stable(mgmt_wdata_o));
  assert_one_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ok_o, no_phy_o, rst_tmo_o, an_fail_o}) <= 1);
  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_start_only_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  assert_clear_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(ok_o || no_phy_o || rst_tmo_o || an_fail_o || spd100_o || fdx_o));
  assert_ctl_words_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_req_o && mgmt_we_o && (mgmt_reg_o == REG_CTL) |->
      (mgmt_wdata_o == 16'h8000) || (mgmt_wdata_o == 16'h1200) || (mgmt_wdata_o == 16'h3300));
endmodule

// File: tb/tb_phy_autoneg_seq.sv
module tb_phy_autoneg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LIMIT  = 20000;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, tick_i = 1'b0;
  logic mgmt_req_o, mgmt_we_o, mgmt_ack_i = 1'b0;
  logic [4:0] mgmt_phy_o, mgmt_reg_o, phy_addr_o;
  logic [15:0] mgmt_wdata_o, mgmt_rdata_i = '0;
  logic busy_o, done_o, ok_o, no_phy_o, rst_tmo_o, an_fail_o, spd100_o, fdx_o;

  phy_autoneg_seq dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // behavioural PHY
  logic [15:0] id1_m [32];
  logic [15:0] id2_m [32];
  logic [15:0] caps, r18;
  int rst_busy, cmp_at, rf_lo, rf_hi;
  int ctl_reads, st_reads;
  logic [26:0] act_q[$];
  logic [26:0] exp_q[$];
  bit e_ok, e_nophy, e_rst, e_an, e_spd, e_fdx;
  int e_phy;

  function automatic logic [26:0] ent(bit we, int phy, int rg, logic [15:0] d);
    return {we, 5'(phy), 5'(rg), d};
  endfunction

  function automatic bit id_valid(logic [15:0] a, logic [15:0] b);
    return a != 16'h0000 && a != 16'hFFFF && a != 16'h8000 &&
           b != 16'h0000 && b != 16'hFFFF && b != 16'h8000;
  endfunction

  function automatic logic [15:0] phy_read(int phy, int rg);
    logic [15:0] v;
    int k;
    v = '0;
    case (rg)
      2: v = id1_m[phy];
      3: v = id2_m[phy];
      0: begin ctl_reads++; v = (ctl_reads <= rst_busy) ? 16'h8000 : 16'h0000; end
      1: begin
        st_reads++;
        k = st_reads - 1;
        v = caps;
        if (k > 0) begin
          if (k >= cmp_at) v[5] = 1'b1;
          if (k >= rf_lo && k <= rf_hi) v[4] = 1'b1;
        end
      end
      18: v = r18;
      default: v = '0;
    endcase
    return v;
  endfunction

  // management engine model with per-clock protocol comparison (R1)
  initial begin
    int lat;
    bit p_req, p_ack;
    logic [26:0] p_fld;
    lat = 0; p_req = 0; p_ack = 0; p_fld = '0;
    forever begin
      @(negedge clk_i);
      if (p_req && !p_ack)
        chk(mgmt_req_o && ({mgmt_we_o, mgmt_phy_o, mgmt_reg_o, mgmt_wdata_o} == p_fld),
            "R1", "request held until acknowledge",
            {mgmt_req_o, mgmt_we_o, mgmt_phy_o, mgmt_reg_o, mgmt_wdata_o}, {1'b1, p_fld});
      p_req = mgmt_req_o;
      p_fld = {mgmt_we_o, mgmt_phy_o, mgmt_reg_o, mgmt_wdata_o};
      mgmt_ack_i = 1'b0;
      if (rst_ni && mgmt_req_o) begin
        lat++;
        if (lat == 2) begin
          lat = 0;
          mgmt_ack_i = 1'b1;
          act_q.push_back(ent(mgmt_we_o, mgmt_phy_o, mgmt_reg_o,
                              mgmt_we_o ? mgmt_wdata_o : 16'h0));
          if (!mgmt_we_o) mgmt_rdata_i = phy_read(mgmt_phy_o, mgmt_reg_o);
        end
      end else lat = 0;
      p_ack = mgmt_ack_i;
    end
  end

  // tick every 4 cycles
  initial begin
    forever begin
      repeat (3) @(negedge clk_i);
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
    end
  end

  task automatic build_exp();
    int p;
    bit done_rst, cmp, rf;
    logic [15:0] adv;
    exp_q.delete();
    {e_ok, e_nophy, e_rst, e_an, e_spd, e_fdx} = '0;
    e_phy = 0;
    p = -1;
    for (int a = 0; a < 32; a++) begin
      exp_q.push_back(ent(0, a, 2, 0));
      exp_q.push_back(ent(0, a, 3, 0));
      if (id_valid(id1_m[a], id2_m[a])) begin p = a; break; end
    end
    if (p < 0) begin e_nophy = 1; return; end
    e_phy = p;
    exp_q.push_back(ent(1, p, 0, 16'h8000));
    done_rst = 0;
    for (int k = 1; k <= 6; k++) begin
      exp_q.push_back(ent(0, p, 0, 0));
      if (k > rst_busy) begin done_rst = 1; break; end
    end
    if (!done_rst) begin e_rst = 1; return; end
    exp_q.push_back(ent(0, p, 18, 0));
    exp_q.push_back(ent(1, p, 19, 16'hFC00));
    exp_q.push_back(ent(0, p, 1, 0));
    adv = 16'h0001;
    adv[9] = caps[15]; adv[8] = caps[14]; adv[7] = caps[13];
    adv[6] = caps[12]; adv[5] = caps[11];
    exp_q.push_back(ent(1, p, 4, adv));
    exp_q.push_back(ent(1, p, 0, 16'h1200));
    for (int k = 1; k <= 20; k++) begin
      exp_q.push_back(ent(0, p, 1, 0));
      cmp = (k >= cmp_at);
      rf  = (k >= rf_lo && k <= rf_hi);
      if (cmp) begin e_an = rf; e_ok = !rf; break; end
      if (k == 20) begin e_an = 1; break; end
      if (rf) exp_q.push_back(ent(1, p, 0, 16'h3300));
    end
    e_spd = r18[7];
    e_fdx = r18[6];
  endtask

  task automatic set_all_ids(logic [15:0] a, logic [15:0] b);
    for (int i = 0; i < 32; i++) begin id1_m[i] = a; id2_m[i] = b; end
  endtask

  task automatic run_case(input string rq, input string nm, input bit poke);
    int n;
    build_exp();
    act_q.delete();
    ctl_reads = 0;
    st_reads = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < RUN_LIMIT) begin
      @(negedge clk_i);
      n++;
      start_i = (poke && n == 30);  // R12: start while busy
    end
    start_i = 1'b0;
    chk(n < RUN_LIMIT, rq, {nm, " run finished"}, n, RUN_LIMIT);
    chk(!busy_o, "R12", {nm, " busy low with done"}, busy_o, 0);
    chk(act_q.size() == exp_q.size(), rq, {nm, " transaction count"},
        act_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < act_q.size(); i++)
      chk(act_q[i] == exp_q[i], rq, $sformatf("%s transaction %0d", nm, i),
          act_q[i], exp_q[i]);
    chk({ok_o, no_phy_o, rst_tmo_o, an_fail_o} == {e_ok, e_nophy, e_rst, e_an}, rq,
        {nm, " result flags ok/nophy/rst/an"},
        {ok_o, no_phy_o, rst_tmo_o, an_fail_o}, {e_ok, e_nophy, e_rst, e_an});
    chk({spd100_o, fdx_o} == {e_spd, e_fdx}, "R11", {nm, " speed/duplex"},
        {spd100_o, fdx_o}, {e_spd, e_fdx});
    if (!e_nophy)
      chk(phy_addr_o == 5'(e_phy), "R3", {nm, " phy address"}, phy_addr_o, e_phy);
    @(negedge clk_i);
    chk(!done_o, "R12", {nm, " done one cycle"}, done_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o, mgmt_req_o, ok_o, no_phy_o, rst_tmo_o, an_fail_o, spd100_o, fdx_o} == '0,
        "R13", "reset state", {busy_o, done_o, mgmt_req_o, ok_o, no_phy_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !mgmt_req_o, "R13", "idle after reset", busy_o, 0);

    // R2 R3 R5 R6 R7 R8 R10 R11 R12: skip invalid ids, found at 3, start poked mid-run
    set_all_ids(16'hFFFF, 16'hFFFF);
    id1_m[0] = 16'hFFFF; id2_m[0] = 16'h1234;
    id1_m[1] = 16'h0000; id2_m[1] = 16'h1234;
    id1_m[2] = 16'h0022; id2_m[2] = 16'h8000;
    id1_m[3] = 16'h0022; id2_m[3] = 16'h5611;
    rst_busy = 1; caps = 16'hF800; cmp_at = 3; rf_lo = 99; rf_hi = 0; r18 = 16'h00C0;
    run_case("R2", "found at 3", 1'b1);

    // R4: nothing qualifies
    set_all_ids(16'hFFFF, 16'hFFFF);
    run_case("R4", "no phy", 1'b0);

    // R5: reset never clears
    set_all_ids(16'hFFFF, 16'hFFFF);
    id1_m[0] = 16'h0101; id2_m[0] = 16'h0202;
    rst_busy = 100;
    run_case("R5", "reset timeout", 1'b0);

    // R9 R7: fault on first poll, restart, then clean completion; found at 31
    set_all_ids(16'h0000, 16'h0000);
    id1_m[31] = 16'h0282; id2_m[31] = 16'h1C51;
    rst_busy = 0; caps = 16'h2800; cmp_at = 2; rf_lo = 1; rf_hi = 1; r18 = 16'h0040;
    run_case("R9", "fault then ok", 1'b0);

    // R10: completion with fault still present
    set_all_ids(16'hFFFF, 16'hFFFF);
    id1_m[5] = 16'h8001; id2_m[5] = 16'h7FFF;
    rst_busy = 2; caps = 16'h0000; cmp_at = 2; rf_lo = 1; rf_hi = 2; r18 = 16'h0080;
    run_case("R10", "complete with fault", 1'b0);

    // R8 R10: never completes, 20 polls
    rst_busy = 0; caps = 16'h5000; cmp_at = 99; rf_lo = 99; rf_hi = 0; r18 = 16'h0000;
    run_case("R8", "negotiation timeout", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule